// File: doc/BRIEF.md
# Timestamped Control Command Executor

This block consumes a control stream of 32-bit words and runs each command at a chosen moment in sample time. A command is an opcode word, then a 32-bit timestamp word, then one or two argument words. After the last argument has been taken in, the block holds the command until the free-running sample counter, supplied from outside, reaches the timestamp. It then performs the command. A command can write a word into a small local register bank, or it can start a write or a read on one of two serial master ports, one SPI-type and one I2C-type. Both ports use a request/acknowledge handshake. Read results come back on a response stream, tagged with the opcode that asked for them.

Only one command is in flight at any time, and commands run in the order they arrived. An unknown opcode sets a sticky error flag, and the parser throws words away up to the end of that payload. A command whose time has already gone by when its last word arrives runs at once and sets a sticky late flag. The sample counter is compared with wrap-around arithmetic, so schedules that cross the counter's rollover behave correctly.

Top module: `timed_cmd_exec`

## Requirements
- R1: After reset: `in_ready` is 1; `rsp_valid`, `spi_req`, `i2c_req`, `fire`, `late_seen` and `bad_op_seen` are 0; every register in `reg_bank` is zero.
- R2: Word layout: the opcode is bits [7:0] of the first word, the timestamp is the second word, and then come the arguments. Opcode 0x01 takes two arguments, an address word (only its low log2(N_REGS) bits are used) and a data word, and writes that data into register `reg_bank[addr*32 +: 32]` on the clock edge that ends the `fire` cycle.
- R3: A command whose timestamp is still in the future when its last word is accepted raises `fire` (with `fire_op` equal to its opcode) in exactly the cycle where `time_now` equals the timestamp, and in no earlier cycle.
- R4: A command whose timestamp lies strictly before `time_now` in the cycle its last word is accepted fires in the next cycle, and `late_seen` becomes 1 and stays 1 until reset. A command that is on time leaves `late_seen` unchanged.
- R5: Opcodes 0x02 (write, `spi_we`=1) and 0x03 (read, `spi_we`=0) take one argument word, which is sent on `spi_wdata`. `spi_req` rises one cycle after `fire` and stays high, with stable `spi_we`/`spi_wdata`, until `spi_ack` is sampled high.
- R6: Opcodes 0x04 (write) and 0x05 (read) do the same on the `i2c_*` port, and the SPI port stays idle while they run.
- R7: A read completes only when the port's `done` input is sampled high after the acknowledge. `rsp_valid` then presents `rsp_op` (the read opcode) together with the sampled `rdata`, and both are held until `rsp_ready` is high.
- R8: Any opcode outside 0x01..0x05 makes `bad_op_seen` 1 until reset. Every word up to and including the next word with `in_last` is then discarded without being run, and parsing starts again at the following word.
- R9: Commands run one at a time in arrival order. `in_ready` is 0 from the acceptance of a command's last word until its register write has happened, its write has been acknowledged, or its response has been taken.
- R10: "Reached" means that (`time_now` − timestamp) mod 2^32, read as a signed number, is ≥ 0. A timestamp just past the counter's rollover therefore waits for the rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| time_now | input | 32 | Free-running sample counter |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Command word accepted when high together with valid |
| in_data | input | 32 | Command word |
| in_last | input | 1 | Marks the final word of a payload |
| spi_req | output | 1 | SPI master request |
| spi_we | output | 1 | SPI request is a write |
| spi_wdata | output | 32 | SPI argument word |
| spi_ack | input | 1 | SPI request accepted |
| spi_done | input | 1 | SPI read data ready |
| spi_rdata | input | 32 | SPI read data |
| i2c_req | output | 1 | I2C master request |
| i2c_we | output | 1 | I2C request is a write |
| i2c_wdata | output | 32 | I2C argument word |
| i2c_ack | input | 1 | I2C request accepted |
| i2c_done | input | 1 | I2C read data ready |
| i2c_rdata | input | 32 | I2C read data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_op | output | 8 | Opcode of the read that produced the response |
| rsp_data | output | 32 | Read data |
| reg_bank | output | N_REGS*32 | Contents of the register bank, register 0 in the low word |
| fire | output | 1 | High in the cycle a command is issued |
| fire_op | output | 8 | Opcode being issued |
| late_seen | output | 1 | Sticky: a command arrived after its time |
| bad_op_seen | output | 1 | Sticky: an unknown opcode was parsed |

## Verification
If the timestamp compare goes wrong, `fire` moves away from the cycle in which `time_now` equals the timestamp. A flaw in the wrap handling shows up at once, as a fire right after parsing, for a timestamp just past rollover. A parser that drifts out of step makes argument words act as opcodes. The result is an unexpected `fire`, a wrong `fire_op`, or a stray `bad_op_seen` within a few cycles. Faults in the handshake states show up as a request that drops before its acknowledge, a response before `done`, or `in_ready` returning while a command is still outstanding. Each of these appears in the cycle it happens.

// File: rtl/timed_cmd_pkg.sv
package timed_cmd_pkg;
  localparam int TS_W = 32;

  localparam logic [7:0] OP_REG    = 8'h01;
  localparam logic [7:0] OP_SPI_WR = 8'h02;
  localparam logic [7:0] OP_SPI_RD = 8'h03;
  localparam logic [7:0] OP_I2C_WR = 8'h04;
  localparam logic [7:0] OP_I2C_RD = 8'h05;

  typedef enum logic [2:0] {
    S_OP, S_TS, S_A0, S_A1, S_WAIT, S_BUSY, S_RSP, S_SKIP
  } seq_state_e;

  function automatic logic op_known(input logic [7:0] op);
    return (op >= OP_REG) && (op <= OP_I2C_RD);
  endfunction

  function automatic logic op_two_args(input logic [7:0] op);
    return op == OP_REG;
  endfunction

  function automatic logic op_is_read(input logic [7:0] op);
    return (op == OP_SPI_RD) || (op == OP_I2C_RD);
  endfunction

  // 0 selects the SPI port, 1 the I2C port
  function automatic logic op_port(input logic [7:0] op);
    return (op == OP_I2C_WR) || (op == OP_I2C_RD);
  endfunction

  // wrap-aware: now is at or after ts
  function automatic logic time_reached(input logic [TS_W-1:0] now, input logic [TS_W-1:0] ts);
    logic [TS_W-1:0] d;
    d = now - ts;
    return !d[TS_W-1];
  endfunction

  // wrap-aware: now is strictly after ts
  function automatic logic time_past(input logic [TS_W-1:0] now, input logic [TS_W-1:0] ts);
    logic [TS_W-1:0] d;
    d = now - ts;
    return !d[TS_W-1] && (d != '0);
  endfunction
endpackage

// File: rtl/cmd_regfile.sv
module cmd_regfile #(
  parameter int N_REGS = 4,
  parameter int DATA_W = 32,
  localparam int AW = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [N_REGS*DATA_W-1:0] bank
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q <= '0;
      else if (we && (addr == AW'(g)))  q <= wdata;
    end
    assign bank[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/cmd_bus_port.sv
module cmd_bus_port #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              req,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  input  logic              ack,
  input  logic              done,
  input  logic [DATA_W-1:0] rdata,
  output logic              finish,
  output logic [DATA_W-1:0] result
);
  typedef enum logic [1:0] {P_IDLE, P_REQ, P_DONE} port_state_e;
  port_state_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= P_IDLE; req <= 1'b0; we <= 1'b0; wdata <= '0;
      finish <= 1'b0; result <= '0;
    end else begin
      finish <= 1'b0;
      case (st)
        P_IDLE: if (start) begin
          req <= 1'b1; we <= start_we; wdata <= start_wdata; st <= P_REQ;
        end
        P_REQ: if (ack) begin
          req <= 1'b0;
          if (we) begin finish <= 1'b1; st <= P_IDLE; end
          else    st <= P_DONE;
        end
        P_DONE: if (done) begin
          result <= rdata; finish <= 1'b1; st <= P_IDLE;
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  // request must not drop or change before it is acknowledged
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req && $stable(wdata) && $stable(we));
endmodule

// File: rtl/timed_cmd_exec.sv
module timed_cmd_exec
  import timed_cmd_pkg::*;
#(
  parameter int N_REGS = 4,
  parameter int DATA_W = 32,
  localparam int AW = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TS_W-1:0]          time_now,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [31:0]              in_data,
  input  logic                     in_last,
  output logic                     spi_req,
  output logic                     spi_we,
  output logic [DATA_W-1:0]        spi_wdata,
  input  logic                     spi_ack,
  input  logic                     spi_done,
  input  logic [DATA_W-1:0]        spi_rdata,
  output logic                     i2c_req,
  output logic                     i2c_we,
  output logic [DATA_W-1:0]        i2c_wdata,
  input  logic                     i2c_ack,
  input  logic                     i2c_done,
  input  logic [DATA_W-1:0]        i2c_rdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [7:0]               rsp_op,
  output logic [DATA_W-1:0]        rsp_data,
  output logic [N_REGS*DATA_W-1:0] reg_bank,
  output logic                     fire,
  output logic [7:0]               fire_op,
  output logic                     late_seen,
  output logic                     bad_op_seen
);
  seq_state_e        st;
  logic [7:0]        op_q;
  logic [TS_W-1:0]   ts_q;
  logic [DATA_W-1:0] a0_q, a1_q;

  // named internal events
  logic accept, last_arg, reached, reg_we, issue, finish_any;
  logic [1:0] p_start, p_req, p_we, p_ack, p_done, p_finish;
  logic [DATA_W-1:0] p_wdata [2];
  logic [DATA_W-1:0] p_rdata [2];
  logic [DATA_W-1:0] p_result [2];
  logic [DATA_W-1:0] result_sel;

  assign in_ready   = (st == S_OP) || (st == S_TS) || (st == S_A0) ||
                      (st == S_A1) || (st == S_SKIP);
  assign accept     = in_valid && in_ready;
  assign last_arg   = accept && (((st == S_A0) && !op_two_args(op_q)) || (st == S_A1));
  assign reached    = time_reached(time_now, ts_q);
  assign fire       = (st == S_WAIT) && reached;
  assign fire_op    = op_q;
  assign reg_we     = fire && (op_q == OP_REG);
  assign issue      = fire && (op_q != OP_REG);
  assign finish_any = |p_finish;
  assign result_sel = p_finish[1] ? p_result[1] : p_result[0];
  assign rsp_op     = op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_OP; op_q <= '0; ts_q <= '0; a0_q <= '0; a1_q <= '0;
      rsp_valid <= 1'b0; rsp_data <= '0; late_seen <= 1'b0; bad_op_seen <= 1'b0;
    end else begin
      if (last_arg && time_past(time_now, ts_q)) late_seen <= 1'b1;
      case (st)
        S_OP: if (accept) begin
          op_q <= in_data[7:0];
          if (op_known(in_data[7:0])) st <= S_TS;
          else begin
            bad_op_seen <= 1'b1;
            st <= in_last ? S_OP : S_SKIP;
          end
        end
        S_TS: if (accept) begin ts_q <= in_data; st <= S_A0; end
        S_A0: if (accept) begin
          a0_q <= in_data;
          st <= op_two_args(op_q) ? S_A1 : S_WAIT;
        end
        S_A1: if (accept) begin a1_q <= in_data; st <= S_WAIT; end
        S_WAIT: if (reached) st <= (op_q == OP_REG) ? S_OP : S_BUSY;
        S_BUSY: if (finish_any) begin
          if (op_is_read(op_q)) begin
            rsp_data <= result_sel; rsp_valid <= 1'b1; st <= S_RSP;
          end else st <= S_OP;
        end
        S_RSP: if (rsp_ready) begin rsp_valid <= 1'b0; st <= S_OP; end
        S_SKIP: if (accept && in_last) st <= S_OP;
        default: st <= S_OP;
      endcase
    end
  end

  cmd_regfile #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(a0_q[AW-1:0]),
    .wdata(a1_q), .bank(reg_bank));

  assign p_ack  = {i2c_ack, spi_ack};
  assign p_done = {i2c_done, spi_done};
  assign p_rdata[0] = spi_rdata;
  assign p_rdata[1] = i2c_rdata;

  for (genvar g = 0; g < 2; g++) begin : g_port
    assign p_start[g] = issue && (op_port(op_q) == g[0]);
    cmd_bus_port #(.DATA_W(DATA_W)) u_port (
      .clk(clk), .rst_n(rst_n), .start(p_start[g]), .start_we(!op_is_read(op_q)),
      .start_wdata(a0_q), .req(p_req[g]), .we(p_we[g]), .wdata(p_wdata[g]),
      .ack(p_ack[g]), .done(p_done[g]), .rdata(p_rdata[g]),
      .finish(p_finish[g]), .result(p_result[g]));
  end

  assign spi_req = p_req[0];  assign spi_we = p_we[0];  assign spi_wdata = p_wdata[0];
  assign i2c_req = p_req[1];  assign i2c_we = p_we[1];  assign i2c_wdata = p_wdata[1];

  assert_one_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_req && i2c_req));
  assert_no_input_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req || i2c_req || rsp_valid) |-> !in_ready);
  assert_rsp_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_op));
  assert_rsp_is_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_op == OP_SPI_RD) || (rsp_op == OP_I2C_RD));
  assert_bad_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op_seen |=> bad_op_seen);
  assert_late_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    late_seen |=> late_seen);
endmodule

// File: tb/timed_cmd_exec_tb.sv
module timed_cmd_exec_tb;
  localparam int N_REGS = 4;
  localparam logic [31:0] T0 = 32'hFFFF_FF80;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] time_now;
  always @(posedge clk) time_now <= !rst_n ? T0 : time_now + 32'd1;

  logic in_valid = 0, in_ready, in_last = 0;
  logic [31:0] in_data = '0;
  logic spi_req, spi_we, spi_ack, spi_done, i2c_req, i2c_we, i2c_ack, i2c_done;
  logic [31:0] spi_wdata, spi_rdata, i2c_wdata, i2c_rdata, rsp_data;
  logic rsp_valid, rsp_ready = 1'b1, fire, late_seen, bad_op_seen;
  logic [7:0] rsp_op, fire_op;
  logic [N_REGS*32-1:0] reg_bank;

  timed_cmd_exec #(.N_REGS(N_REGS), .DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .spi_req(spi_req), .spi_we(spi_we), .spi_wdata(spi_wdata), .spi_ack(spi_ack),
    .spi_done(spi_done), .spi_rdata(spi_rdata), .i2c_req(i2c_req), .i2c_we(i2c_we),
    .i2c_wdata(i2c_wdata), .i2c_ack(i2c_ack), .i2c_done(i2c_done), .i2c_rdata(i2c_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op), .rsp_data(rsp_data),
    .reg_bank(reg_bank), .fire(fire), .fire_op(fire_op), .late_seen(late_seen),
    .bad_op_seen(bad_op_seen));

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  function automatic logic [31:0] spi_model(input logic [31:0] a); return a ^ 32'h5A5A_0F0F; endfunction
  function automatic logic [31:0] i2c_model(input logic [31:0] a); return a + 32'h10; endfunction

  typedef struct packed { logic [7:0] op; logic [31:0] ts; logic [31:0] a0; logic [31:0] a1; logic exact; } exp_t;
  typedef struct packed { logic [7:0] op; logic [31:0] d; } rsp_t;
  exp_t fq[$];
  rsp_t rq[$];
  exp_t last_fire = '0;
  logic [31:0] mregs [N_REGS];
  bit pend = 0;
  int pend_idx = 0;
  logic [31:0] pend_val = '0;

  function automatic logic [N_REGS*32-1:0] model_flat();
    logic [N_REGS*32-1:0] f;
    for (int i = 0; i < N_REGS; i++) f[i*32 +: 32] = mregs[i];
    return f;
  endfunction

  task automatic put_word(input logic [31:0] d, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // driver: pushes the expected issue, then sends the words
  task automatic send(input logic [7:0] op, input logic [31:0] ts, input logic [31:0] a0,
                      input logic [31:0] a1, input logic exact);
    fq.push_back({op, ts, a0, a1, exact});
    put_word({24'h0, op}, 1'b0);
    put_word(ts, 1'b0);
    if (op == 8'h01) begin put_word(a0, 1'b0); put_word(a1, 1'b1); end
    else put_word(a0, 1'b1);
  endtask

  task automatic wait_idle();
    while (fq.size() != 0 || rq.size() != 0 || !in_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) if (rst_n) begin
    if (pend) begin
      mregs[pend_idx] = pend_val; pend = 0;
      chk(reg_bank == model_flat(), "R2 register bank after write", reg_bank[31:0], mregs[0]);
    end
    if (fire) begin
      if (fq.size() == 0) chk(0, "R8 unexpected fire", {24'h0, fire_op}, 32'h0);
      else begin
        exp_t e;
        e = fq.pop_front();
        chk(fire_op == e.op, "R9 issue order", {24'h0, fire_op}, {24'h0, e.op});
        if (e.exact) chk(time_now == e.ts, "R3 R10 fire cycle", time_now, e.ts);
        else begin
          chk($signed(time_now - e.ts) > 0, "R4 late fire", time_now, e.ts);
          chk(late_seen, "R4 late flag", {31'h0, late_seen}, 32'h1);
        end
        last_fire = e;
        if (e.op == 8'h01) begin pend = 1; pend_idx = int'(e.a0 % N_REGS); pend_val = e.a1; end
        if (e.op == 8'h03) rq.push_back({e.op, spi_model(e.a0)});
        if (e.op == 8'h05) rq.push_back({e.op, i2c_model(e.a0)});
      end
    end
    if (rsp_valid && rsp_ready) begin
      if (rq.size() == 0) chk(0, "R7 unexpected response", rsp_data, 32'h0);
      else begin
        rsp_t r;
        r = rq.pop_front();
        chk(rsp_op == r.op, "R7 response tag", {24'h0, rsp_op}, {24'h0, r.op});
        chk(rsp_data == r.d, "R7 response data", rsp_data, r.d);
      end
    end
  end

  // SPI master model
  initial begin
    spi_ack = 0; spi_done = 0; spi_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && spi_req) begin
        logic w;
        w = spi_we;
        chk(spi_wdata == last_fire.a0, "R5 spi argument", spi_wdata, last_fire.a0);
        chk(w == (last_fire.op == 8'h02), "R5 spi direction", {31'h0, w}, 32'h0);
        chk(!i2c_req, "R6 other port idle", {31'h0, i2c_req}, 32'h0);
        repeat (2) begin @(negedge clk); chk(spi_req, "R5 spi req held", {31'h0, spi_req}, 32'h1); end
        spi_ack = 1; @(negedge clk); spi_ack = 0;
        if (!w) begin
          repeat (3) begin @(negedge clk); chk(!rsp_valid, "R7 no response before done", {31'h0, rsp_valid}, 32'h0); end
          spi_rdata = spi_model(last_fire.a0); spi_done = 1; @(negedge clk); spi_done = 0;
        end
      end
    end
  end

  // I2C master model
  initial begin
    i2c_ack = 0; i2c_done = 0; i2c_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && i2c_req) begin
        logic w;
        w = i2c_we;
        chk(i2c_wdata == last_fire.a0, "R6 i2c argument", i2c_wdata, last_fire.a0);
        chk(w == (last_fire.op == 8'h04), "R6 i2c direction", {31'h0, w}, 32'h0);
        chk(!spi_req, "R6 spi idle", {31'h0, spi_req}, 32'h0);
        repeat (3) @(negedge clk);
        i2c_ack = 1; @(negedge clk); i2c_ack = 0;
        if (!w) begin
          repeat (2) @(negedge clk);
          i2c_rdata = i2c_model(last_fire.a0); i2c_done = 1; @(negedge clk); i2c_done = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", fq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] t, held;
    for (int i = 0; i < N_REGS; i++) mregs[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready, "R1 in_ready", {31'h0, in_ready}, 32'h1);
    chk(!rsp_valid && !spi_req && !i2c_req && !fire, "R1 outputs idle", {28'h0, rsp_valid, spi_req, i2c_req, fire}, 32'h0);
    chk(!late_seen && !bad_op_seen, "R1 flags clear", {30'h0, late_seen, bad_op_seen}, 32'h0);
    chk(reg_bank == '0, "R1 registers zero", reg_bank[31:0], 32'h0);

    // R10 timestamp beyond counter rollover
    while (time_now != 32'hFFFF_FFF0) @(negedge clk);
    send(8'h01, 32'h0000_0010, 32'h1, 32'hDEAD_BEEF, 1'b1);
    @(negedge clk);
    chk(!in_ready, "R9 input blocked while waiting", {31'h0, in_ready}, 32'h0);
    wait_idle();
    chk(!late_seen, "R4 on-time leaves late clear", {31'h0, late_seen}, 32'h0);

    // R2 address uses low bits only (6 -> register 2)
    send(8'h01, time_now + 32'd25, 32'h6, 32'h1234_5678, 1'b1);
    wait_idle();
    send(8'h02, time_now + 32'd30, 32'hA1B2_C3D4, 32'h0, 1'b1);   // R5 write
    wait_idle();
    send(8'h03, time_now + 32'd30, 32'h0000_0055, 32'h0, 1'b1);   // R5 R7 read
    wait_idle();
    send(8'h04, time_now + 32'd30, 32'h0BAD_F00D, 32'h0, 1'b1);   // R6 write
    wait_idle();
    send(8'h05, time_now + 32'd30, 32'h0000_7700, 32'h0, 1'b1);   // R6 R7 read
    wait_idle();

    // R7 response back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    send(8'h03, time_now + 32'd20, 32'h0000_0F00, 32'h0, 1'b1);
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    repeat (4) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == held, "R7 response held", rsp_data, held);
      chk(!in_ready, "R9 input blocked during response", {31'h0, in_ready}, 32'h0);
    end
    @(posedge clk); #1 rsp_ready = 1'b1;
    wait_idle();
    chk(!late_seen, "R4 late still clear", {31'h0, late_seen}, 32'h0);

    // R9 order, R4 late: second command's time passes while first waits
    t = time_now;
    send(8'h01, t + 32'd30, 32'h0, 32'h0000_AAAA, 1'b1);
    send(8'h01, t + 32'd10, 32'h3, 32'h0000_BBBB, 1'b0);
    wait_idle();
    chk(late_seen, "R4 sticky late", {31'h0, late_seen}, 32'h1);

    // R8 unknown opcode skips to end of payload
    put_word(32'h0000_007E, 1'b0);
    put_word(32'h0000_0001, 1'b0);
    put_word(32'h0000_0033, 1'b1);
    chk(bad_op_seen, "R8 error flag", {31'h0, bad_op_seen}, 32'h1);
    put_word(32'h0000_00FF, 1'b1);
    send(8'h01, time_now + 32'd20, 32'h2, 32'h00C0_FFEE, 1'b1);
    wait_idle();
    chk(bad_op_seen, "R8 error flag sticky", {31'h0, bad_op_seen}, 32'h1);
    chk(reg_bank == model_flat(), "R8 skipped words wrote nothing", reg_bank[63:32], mregs[1]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule